// File: doc/BRIEF.md
# Operand Effective-Address Decoder

This block parses the addressing bytes of one instruction operand. It takes one byte per cycle over a valid/ready handshake. The first byte is the ModRM byte. Depending on its fields, the block then takes a scale-index-base (SIB) byte and an 8-bit or 32-bit displacement. It then reports one of two results: a register operand, or the effective address of a memory operand. It also reports how many bytes it consumed.

The surrounding decoder supplies the following inputs:
- the long-mode (64-bit) flag;
- the two REX extension bits, one for the base and one for the index;
- the address of the following instruction, used for RIP-relative forms;
- the sixteen general-purpose register values as one flat vector.

The result is shown for exactly one cycle. The block then waits for the next ModRM byte. Opcodes, other prefixes, segmentation and 16-bit forms are not handled.

Top module: `ea_decode`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_done` is 0.
- R2: ModRM layout: mode is bits [7:6], register field is bits [5:3] (ignored), r/m is bits [2:0]. Mode 11 gives a register operand: `out_is_reg`=1, `out_reg`={ext_base, r/m}, `out_len`=1, `out_addr`=0.
- R3: Mode 01 appends one displacement byte, sign-extended to 64 bits. Mode 10 appends four bytes, least significant first, sign-extended. The address is base register + displacement.
- R4: For a memory mode with r/m=100, a SIB byte follows. Its fields are scale [7:6], index [5:3] and base [2:0]. The address is base + (index << scale) + displacement, so the scale factors are 1, 2, 4 and 8.
- R5: An extended index of 0100 (ext_index=0, index=100) contributes nothing. An extended index of 1100 is a normal index (register 12).
- R6: Mode 00 with r/m low bits 101, whatever ext_base is, has no base and takes a 4-byte displacement. In long mode the address is next_pc + displacement. Otherwise it is the displacement alone.
- R7: Mode 00 with a SIB base of 101 has no base and takes a 4-byte displacement, for 6 bytes in total. With mode 01 and a SIB base of 101, register 5 is the base, plus the 8-bit displacement.
- R8: ext_base forms bit 3 of the r/m or SIB base register number. ext_index forms bit 3 of the index register number.
- R9: Address arithmetic wraps modulo 2^64. When long mode is off, bits [63:32] of the address are zero.
- R10: `out_done` is high for exactly one cycle, with `in_ready` low during that cycle. In the next cycle `in_ready` is high again for a new ModRM byte. Cycles with `in_valid` low are idle and leave the parse unchanged.
- R11: `out_done` rises in the cycle after the final byte is accepted. `out_len` runs from 1 to 6. The extension bits are captured with the ModRM byte. The register values, next_pc and the long-mode flag are used during the done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Byte on `in_byte` is valid |
| in_byte | input | 8 | Instruction byte stream |
| in_ready | output | 1 | Block can accept a byte |
| long_mode | input | 1 | 64-bit mode |
| ext_base | input | 1 | Base / r/m register extension bit |
| ext_index | input | 1 | Index register extension bit |
| next_pc | input | 64 | Address of the following instruction |
| gpr_flat | input | 1024 | Register i at bits [64*i+63:64*i] |
| out_done | output | 1 | Result valid (one cycle) |
| out_is_reg | output | 1 | Operand is a register |
| out_reg | output | 4 | Register number for a register operand |
| out_addr | output | 64 | Effective address for a memory operand |
| out_len | output | 3 | Bytes consumed |

## Verification
The bench targets the escape encodings, each of which fails in a recognisable way.

- A decoder that treated r/m=100 as a plain base would read the stack-pointer register and stop one byte early.
- A decoder that missed the mode-00 base-101 case, including the r13 form with ext_base set, would add register 5 and never wait for the four displacement bytes.
- Testing the index for no-index on all four bits matters. Testing only the low three bits would drop register 12 from the sum.
- Further cases cover sign extension of 8-bit and 32-bit displacements, the byte order of the 32-bit displacement, and the RIP-relative versus absolute result under the mode flag.
- Other cases cover truncation to 32 bits, frame-pointer base with a zero 8-bit displacement, and input stalls between bytes. A design that counted idle cycles as bytes would give the wrong length and address.

// File: rtl/ea_pkg.sv
`timescale 1ns/1ps
package ea_pkg;

  typedef enum logic [1:0] {
    ST_MODRM = 2'd0,
    ST_SIB   = 2'd1,
    ST_DISP  = 2'd2,
    ST_DONE  = 2'd3
  } ea_state_t;

  // Captured addressing fields of one operand.
  typedef struct packed {
    logic [1:0]  mode;
    logic [2:0]  rm;
    logic        has_sib;
    logic [1:0]  scale;
    logic [2:0]  idx;
    logic [2:0]  base;
    logic        ext_b;
    logic        ext_x;
    logic [2:0]  disp_len;
    logic [31:0] disp;
  } ea_fields_t;

  // Displacement byte count implied by the mode and the low base bits.
  function automatic logic [2:0] disp_bytes(input logic [1:0] mode,
                                            input logic [2:0] low_base);
    logic [2:0] n;
    case (mode)
      2'b01:   n = 3'd1;
      2'b10:   n = 3'd4;
      2'b00:   n = (low_base == 3'b101) ? 3'd4 : 3'd0;
      default: n = 3'd0;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/ea_rst_sync.sv
`timescale 1ns/1ps
module ea_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/ea_byte_seq.sv
`timescale 1ns/1ps
module ea_byte_seq
  import ea_pkg::*;
#(
  parameter int LEN_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       in_byte,
  input  logic             ext_base,
  input  logic             ext_index,
  output logic             in_ready,
  output logic             done,
  output logic [LEN_W-1:0] len,
  output ea_fields_t       fields
);
  ea_state_t        state_q, state_n;
  ea_fields_t       flds_q, flds_n;
  logic [2:0]       rem_q, rem_n;
  logic [LEN_W-1:0] len_q, len_n;
  logic             accept;
  logic             ld_en;

  assign accept = in_valid && (state_q != ST_DONE);
  assign ld_en  = accept;

  always_comb begin
    logic [2:0] dl;
    logic [2:0] pos;
    dl      = '0;
    pos     = '0;
    state_n = state_q;
    flds_n  = flds_q;
    rem_n   = rem_q;
    len_n   = len_q;
    case (state_q)
      ST_MODRM: if (accept) begin
        flds_n       = '0;
        flds_n.mode  = in_byte[7:6];
        flds_n.rm    = in_byte[2:0];
        flds_n.ext_b = ext_base;
        flds_n.ext_x = ext_index;
        len_n        = LEN_W'(1);
        rem_n        = '0;
        if (in_byte[7:6] == 2'b11) begin
          state_n = ST_DONE;
        end else if (in_byte[2:0] == 3'b100) begin
          flds_n.has_sib = 1'b1;
          state_n        = ST_SIB;
        end else begin
          dl              = disp_bytes(in_byte[7:6], in_byte[2:0]);
          flds_n.disp_len = dl;
          rem_n           = dl;
          state_n         = (dl == 3'd0) ? ST_DONE : ST_DISP;
        end
      end
      ST_SIB: if (accept) begin
        flds_n.scale    = in_byte[7:6];
        flds_n.idx      = in_byte[5:3];
        flds_n.base     = in_byte[2:0];
        len_n           = len_q + LEN_W'(1);
        dl              = disp_bytes(flds_q.mode, in_byte[2:0]);
        flds_n.disp_len = dl;
        rem_n           = dl;
        state_n         = (dl == 3'd0) ? ST_DONE : ST_DISP;
      end
      ST_DISP: if (accept) begin
        pos = flds_q.disp_len - rem_q;
        flds_n.disp[{pos[1:0], 3'b000} +: 8] = in_byte;
        rem_n = rem_q - 3'd1;
        len_n = len_q + LEN_W'(1);
        if (rem_q == 3'd1) state_n = ST_DONE;
      end
      default: state_n = ST_MODRM;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_MODRM;
    else        state_q <= state_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flds_q <= '0;
      rem_q  <= '0;
      len_q  <= '0;
    end else if (ld_en) begin
      flds_q <= flds_n;
      rem_q  <= rem_n;
      len_q  <= len_n;
    end
  end

  assign in_ready = (state_q != ST_DONE);
  assign done     = (state_q == ST_DONE);
  assign len      = len_q;
  assign fields   = flds_q;

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_ready_back_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> in_ready);
  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !done) |=> ($stable(state_q) && $stable(len_q)));
  assert_len_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (len_q >= LEN_W'(1) && len_q <= LEN_W'(6)));
  assert_reg_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && flds_q.mode == 2'b11) |-> len_q == LEN_W'(1));
  assert_disp_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DISP) |-> rem_q != 3'd0);
endmodule

// File: rtl/ea_addr_calc.sv
`timescale 1ns/1ps
module ea_addr_calc
  import ea_pkg::*;
#(
  parameter int AW   = 64,
  parameter int NREG = 16,
  localparam int RW  = $clog2(NREG)
) (
  input  ea_fields_t         fields,
  input  logic               long_mode,
  input  logic [AW-1:0]      next_pc,
  input  logic [AW*NREG-1:0] gpr_flat,
  output logic               is_reg,
  output logic [RW-1:0]      reg_num,
  output logic [AW-1:0]      addr
);
  logic [RW-1:0] base_num, idx_num;
  logic          no_base, no_idx, rip_rel;
  logic [AW-1:0] base_val, idx_val, disp_val, sum;

  always_comb begin
    is_reg   = (fields.mode == 2'b11);
    reg_num  = is_reg ? {fields.ext_b, fields.rm} : '0;
    if (fields.has_sib) begin
      base_num = {fields.ext_b, fields.base};
      no_base  = (fields.mode == 2'b00) && (fields.base == 3'b101);
      idx_num  = {fields.ext_x, fields.idx};
      no_idx   = ({fields.ext_x, fields.idx} == 4'b0100);
      rip_rel  = 1'b0;
    end else begin
      base_num = {fields.ext_b, fields.rm};
      no_base  = (fields.mode == 2'b00) && (fields.rm == 3'b101);
      idx_num  = '0;
      no_idx   = 1'b1;
      rip_rel  = no_base && long_mode;
    end

    if (no_base) base_val = rip_rel ? next_pc : '0;
    else         base_val = gpr_flat[AW*base_num +: AW];

    if (no_idx) idx_val = '0;
    else        idx_val = gpr_flat[AW*idx_num +: AW] << fields.scale;

    case (fields.disp_len)
      3'd1:    disp_val = {{(AW-8){fields.disp[7]}}, fields.disp[7:0]};
      3'd4:    disp_val = {{(AW-32){fields.disp[31]}}, fields.disp};
      default: disp_val = '0;
    endcase

    sum = base_val + idx_val + disp_val;
    if (is_reg)         addr = '0;
    else if (long_mode) addr = sum;
    else                addr = {{(AW-32){1'b0}}, sum[31:0]};
  end
endmodule

// File: rtl/ea_decode.sv
`timescale 1ns/1ps
module ea_decode
  import ea_pkg::*;
#(
  parameter int AW    = 64,
  parameter int NREG  = 16,
  parameter int LEN_W = 3,
  localparam int RW   = $clog2(NREG)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [7:0]         in_byte,
  output logic               in_ready,
  input  logic               long_mode,
  input  logic               ext_base,
  input  logic               ext_index,
  input  logic [AW-1:0]      next_pc,
  input  logic [AW*NREG-1:0] gpr_flat,
  output logic               out_done,
  output logic               out_is_reg,
  output logic [RW-1:0]      out_reg,
  output logic [AW-1:0]      out_addr,
  output logic [LEN_W-1:0]   out_len
);
  logic       srst_n;
  ea_fields_t fields;

  ea_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(srst_n)
  );

  ea_byte_seq #(.LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst_n(srst_n), .in_valid(in_valid), .in_byte(in_byte),
    .ext_base(ext_base), .ext_index(ext_index), .in_ready(in_ready),
    .done(out_done), .len(out_len), .fields(fields)
  );

  ea_addr_calc #(.AW(AW), .NREG(NREG)) u_calc (
    .fields(fields), .long_mode(long_mode), .next_pc(next_pc),
    .gpr_flat(gpr_flat), .is_reg(out_is_reg), .reg_num(out_reg),
    .addr(out_addr)
  );

  assert_trunc_R9: assert property (@(posedge clk) disable iff (!srst_n)
    (out_done && !long_mode) |-> out_addr[AW-1:32] == '0);
  assert_reg_noaddr_R2: assert property (@(posedge clk) disable iff (!srst_n)
    (out_done && out_is_reg) |-> (out_addr == '0 && out_len == LEN_W'(1)));
  assert_no_accept_done_R10: assert property (@(posedge clk) disable iff (!srst_n)
    out_done |-> !in_ready);
endmodule

// File: tb/ea_decode_test.sv
`timescale 1ns/1ps
module ea_decode_test;
  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic [7:0]    in_byte;
  logic          in_ready;
  logic          long_mode;
  logic          ext_base;
  logic          ext_index;
  logic [63:0]   next_pc;
  logic [1023:0] gpr_flat;
  logic          out_done;
  logic          out_is_reg;
  logic [3:0]    out_reg;
  logic [63:0]   out_addr;
  logic [2:0]    out_len;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  ea_decode uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .in_ready(in_ready), .long_mode(long_mode), .ext_base(ext_base),
    .ext_index(ext_index), .next_pc(next_pc), .gpr_flat(gpr_flat),
    .out_done(out_done), .out_is_reg(out_is_reg), .out_reg(out_reg),
    .out_addr(out_addr), .out_len(out_len)
  );

  function automatic logic [63:0] rv(input int i);
    return {8'(i + 1), 24'h0, 32'h1000_0000 + 32'(i) * 32'h100};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Send bytes b[7:0] first; gap idle cycles between bytes.
  task automatic feed(input logic [47:0] b, input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_byte  = b[8*i +: 8];
      @(posedge clk);
      if (gap > 0 && i < n - 1) begin
        for (int g = 0; g < gap; g++) begin
          @(negedge clk);
          in_valid = 1'b0;
          chk("R10 no done during stall", 64'(out_done), 64'd0);
          @(posedge clk);
        end
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic after_done(input string tag);
    chk({tag, " done high"}, 64'(out_done), 64'd1);
    chk({tag, " R10 ready low in done"}, 64'(in_ready), 64'd0);
    @(negedge clk);
    chk({tag, " R10 done one cycle"}, 64'(out_done), 64'd0);
    chk({tag, " R10 ready back"}, 64'(in_ready), 64'd1);
  endtask

  task automatic mem_case(input string tag, input logic [47:0] b, input int n,
                          input int gap, input logic [63:0] exp_addr);
    feed(b, n, gap);
    chk({tag, " R11 length"}, 64'(out_len), 64'(n));
    chk({tag, " memory flag"}, 64'(out_is_reg), 64'd0);
    chk({tag, " address"}, out_addr, exp_addr);
    after_done(tag);
  endtask

  task automatic t_reset;
    chk("R1 ready after reset", 64'(in_ready), 64'd1);
    chk("R1 done after reset", 64'(out_done), 64'd0);
  endtask

  task automatic t_register;
    ext_base = 1'b1;
    feed(48'hC3, 1, 0);
    chk("R2 reg flag", 64'(out_is_reg), 64'd1);
    chk("R2 R8 reg number", 64'(out_reg), 64'd11);
    chk("R2 length", 64'(out_len), 64'd1);
    chk("R2 addr zero", out_addr, 64'd0);
    after_done("R2");
    ext_base = 1'b0;
  endtask

  task automatic t_disp;
    mem_case("R3 disp8 neg", {40'h0, 8'hF0, 8'h40}, 2, 0, rv(0) - 64'd16);
    mem_case("R3 disp32 le", {8'h0, 32'h12345678, 8'h81}, 5, 0, rv(1) + 64'h12345678);
    mem_case("R3 disp32 sign", {8'h0, 32'h80000000, 8'h81}, 5, 0, rv(1) - 64'h80000000);
  endtask

  task automatic t_sib;
    mem_case("R4 scale8", {32'h0, 8'hCA, 8'h04}, 2, 0, rv(2) + (rv(1) << 3));
    mem_case("R4 scale2 disp8", {24'h0, 8'h10, 8'h4A, 8'h44}, 3, 0, rv(2) + (rv(1) << 1) + 64'h10);
  endtask

  task automatic t_noindex;
    mem_case("R5 no index", {32'h0, 8'h24, 8'h04}, 2, 0, rv(4));
    ext_index = 1'b1;
    mem_case("R5 R8 r12 index", {32'h0, 8'h24, 8'h04}, 2, 0, rv(4) + rv(12));
    ext_index = 1'b0;
  endtask

  task automatic t_rip;
    mem_case("R6 rip rel", {8'h0, 32'h00000010, 8'h05}, 5, 0, next_pc + 64'h10);
    ext_base = 1'b1;
    mem_case("R6 R8 r13 form", {8'h0, 32'hFFFFFFF0, 8'h05}, 5, 0, next_pc - 64'h10);
    ext_base = 1'b0;
    long_mode = 1'b0;
    mem_case("R6 absolute", {8'h0, 32'h00000010, 8'h05}, 5, 0, 64'h10);
    long_mode = 1'b1;
  endtask

  task automatic t_sib_nobase;
    mem_case("R7 index only", {32'h0, 8'h8D, 8'h04}, 6, 0, rv(1) << 2);
    mem_case("R7 fp base disp8 0", {24'h0, 8'h00, 8'h25, 8'h44}, 3, 0, rv(5));
  endtask

  task automatic t_extbase;
    ext_base = 1'b1;
    mem_case("R8 r8 base", 48'h00, 1, 0, rv(8));
    ext_base = 1'b0;
  endtask

  task automatic t_trunc;
    long_mode = 1'b0;
    mem_case("R9 trunc", {8'h0, 32'hFFFFFFFF, 8'h80}, 5, 0, 64'h0FFF_FFFF);
    long_mode = 1'b1;
    mem_case("R9 wrap 64", {8'h0, 32'hFFFFFFFF, 8'h80}, 5, 0, rv(0) - 64'd1);
  endtask

  task automatic t_stall;
    mem_case("R10 stalled sib disp", {24'h0, 8'h7F, 8'h4A, 8'h44}, 3, 2, rv(2) + (rv(1) << 1) + 64'h7F);
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    rst_n     = 1'b0;
    in_valid  = 1'b0;
    in_byte   = 8'h0;
    long_mode = 1'b1;
    ext_base  = 1'b0;
    ext_index = 1'b0;
    next_pc   = 64'h0000_7FFF_0000_4000;
    for (int i = 0; i < 16; i++) gpr_flat[64*i +: 64] = rv(i);
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_register();
    t_disp();
    t_sib();
    t_noindex();
    t_rip();
    t_sib_nobase();
    t_extbase();
    t_trunc();
    t_stall();
    summary();
  end
endmodule